// File: doc/BRIEF.md
# Hash Block Sequencer

This block sits in front of a multi-algorithm hash compression core. Software or a DMA engine configures a job: the algorithm, whether the digest starts from the algorithm's initial constants or resumes from a saved byte count, whether this job closes the hash, and the job length in bytes. The block then collects 32-bit message words into a sixteen-word input buffer. When the buffer holds a full 64-byte block, or the last bytes of the message have arrived, the block moves the buffer into a working register and frees the input side for the next block. A closing job gets standard padding applied during that move.

Each formatted 512-bit block is offered to the compression core on a valid/ready handshake. The first block of a job that loaded the initial constants is flagged and carries the selected algorithm's initial digest words. The block keeps a running count of message bytes handed to the core, so an unfinished hash can be saved and resumed later. It raises a completion flag, and optionally an active-low interrupt, once the last block has been accepted. In DMA mode it pulses a request each time the input buffer opens for another sixteen words.

Top module: `hash_seq_top`

## Requirements
- R1: `cfg_algo` selects the algorithm: 0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256. `blk_algo` reports the selection. `blk_iv` carries that algorithm's standard initial words, packed from word A in bits 255:224 downward and zero-filled beyond its word count.
- R2: If `cfg_load_iv` is 1 at a start, `digest_cnt` clears to 0 and the first block of the job carries `blk_first`=1. If it is 0, `digest_cnt` loads `cfg_cnt_in` and no block of the job is flagged first.
- R3: A start is accepted only when the block is idle or done. `in_ready` is 1 on the cycle after an accepted start with nonzero length. `in_ready` and `out_ready` are never high together.
- R4: Byte k of the message (k = 0..63 within a block) appears in `blk_data[511-8k -: 8]`. A word written to the buffer supplies four consecutive bytes, most significant byte first.
- R5: With close-hash set, the byte after the message is 0x80. Zero bytes follow up to byte 56 of a block, and bytes 56..63 hold the 64-bit bit length (restored count + job length) x 8. An extra block is added when fewer than 9 bytes remain after the message, including when the message ends exactly on a block boundary.
- R6: The bit length is stored most significant byte first for algorithms 1 to 3 and least significant byte first for algorithm 0.
- R7: With close-hash clear, a job length that is a multiple of 64 produces exactly length/64 blocks, each with the message bytes unchanged and no padding.
- R8: The final word of a message contributes only (length mod 4) bytes, or 4 if that is zero, taken from its most significant end. Its remaining bytes are replaced by padding.
- R9: While `blk_valid` is 1 and `blk_ready` is 0, `blk_valid` and `blk_data` hold. Once a block moves to working storage, `in_ready` returns without waiting for the core if message bytes remain.
- R10: When `dma_en` is 1, `dma_req` pulses for one cycle on each entry into input-ready. That is ceil(length/64) pulses for a job with nonzero length, and none when `dma_en` is 0.
- R11: `out_ready` rises on the cycle after the last block of the job is accepted and stays until the next start. `irq_n` is 0 exactly while `out_ready` and `irq_en` are both 1.
- R12: `digest_cnt` grows by the number of message bytes (not padding) in each accepted block, and ends a job at the start count plus the job length.
- R13: A word written while `in_ready` is 0 changes neither the buffer nor `digest_cnt`. It sets `overflow`, which holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | One-cycle pulse that launches a job |
| cfg_algo | input | 2 | Algorithm select |
| cfg_load_iv | input | 1 | Start from initial constants and clear the byte count |
| cfg_close | input | 1 | This job finishes the hash and gets padding |
| cfg_len | input | LEN_W | Job length in bytes |
| cfg_cnt_in | input | CNT_W | Saved byte count used when not loading constants |
| dma_en | input | 1 | Issue DMA requests when the buffer opens |
| irq_en | input | 1 | Enable the completion interrupt |
| wr_valid | input | 1 | Message word write strobe |
| wr_data | input | 32 | Message word |
| in_ready | output | 1 | Input buffer accepts words |
| dma_req | output | 1 | One-cycle request for the next sixteen words |
| overflow | output | 1 | Sticky flag for writes refused while not ready |
| blk_valid | output | 1 | Formatted block offered to the core |
| blk_ready | input | 1 | Core accepts the block |
| blk_data | output | 512 | Formatted block, byte 0 in the top bits |
| blk_first | output | 1 | Block begins a hash from initial constants |
| blk_algo | output | 2 | Algorithm for the offered block |
| blk_iv | output | 256 | Initial digest words of the algorithm |
| digest_cnt | output | CNT_W | Message bytes handed to the core |
| out_ready | output | 1 | Job complete |
| irq_n | output | 1 | Active-low completion interrupt |

## Verification
`in_ready` and `dma_req` are due on the edge that takes an accepted start. A block is offered on the second edge after the write that completes it, provided the working register is free. `digest_cnt` and `out_ready` change on the edge that accepts the last block, and `overflow` on the edge after a refused write. The bench drives inputs and samples outputs on falling edges, half a cycle after each of those rising edges. It compares every accepted block against a byte queue built from the message and the padding rules. It checks counts, flags and DMA pulse totals at the first falling edge after `out_ready` rises.

// File: rtl/hash_seq_pkg.sv
package hash_seq_pkg;

   localparam int WORD_W    = 32;
   localparam int BLK_WORDS = 16;
   localparam int BLK_BYTES = BLK_WORDS * WORD_W / 8;
   localparam int LEN_BYTES = 8;
   localparam int FILL_W    = $clog2(BLK_BYTES + 1);
   localparam int IV_W      = 256;

   typedef enum logic [1:0] {
      ALG_MD5    = 2'd0,
      ALG_SHA1   = 2'd1,
      ALG_SHA224 = 2'd2,
      ALG_SHA256 = 2'd3
   } alg_e;

   // How the working block is formed from the input buffer
   typedef enum logic [1:0] {
      BK_RAW     = 2'd0,   // buffer as written
      BK_FINAL   = 2'd1,   // data, 0x80 marker, zeros, bit length
      BK_SPILL   = 2'd2,   // data, 0x80 marker, zeros (length follows)
      BK_LENONLY = 2'd3    // zeros and bit length
   } blk_kind_e;

   function automatic logic [IV_W-1:0] iv_words(alg_e a);
      case (a)
         ALG_MD5:    iv_words = {32'h67452301, 32'hefcdab89, 32'h98badcfe,
                                 32'h10325476, 128'h0};
         ALG_SHA1:   iv_words = {32'h67452301, 32'hefcdab89, 32'h98badcfe,
                                 32'h10325476, 32'hc3d2e1f0, 96'h0};
         ALG_SHA224: iv_words = {32'hc1059ed8, 32'h367cd507, 32'h3070dd17,
                                 32'hf70e5939, 32'hffc00b31, 32'h68581511,
                                 32'h64f98fa7, 32'hbefa4fa4};
         default:    iv_words = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372,
                                 32'ha54ff53a, 32'h510e527f, 32'h9b05688c,
                                 32'h1f83d9ab, 32'h5be0cd19};
      endcase
   endfunction

endpackage

// File: rtl/hash_inbuf.sv
module hash_inbuf #(
   parameter int WORDS  = 16,
   parameter int WORD_W = 32,
   localparam int IW    = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IW-1:0]           wr_idx,
   input  logic [WORD_W-1:0]       wr_data,
   output logic [WORDS*WORD_W-1:0] raw_blk
);

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en && wr_idx == IW'(g)) begin
            word_q <= wr_data;
         end
      end
      assign raw_blk[(WORDS-1-g)*WORD_W +: WORD_W] = word_q;
   end

endmodule

// File: rtl/hash_pad.sv
module hash_pad
   import hash_seq_pkg::*;
#(
   parameter int BYTES  = 64,
   parameter int LBYTES = 8,
   localparam int RW    = $clog2(BYTES + 1)
) (
   input  logic [BYTES*8-1:0]  raw_blk,
   input  blk_kind_e           kind,
   input  logic [RW-1:0]       fill_r,
   input  logic                little_len,
   input  logic [LBYTES*8-1:0] bit_len,
   output logic [BYTES*8-1:0]  blk_out
);

   logic mark_en, len_en;
   assign mark_en = (kind == BK_FINAL) || (kind == BK_SPILL);
   assign len_en  = (kind == BK_FINAL) || (kind == BK_LENONLY);

   for (genvar i = 0; i < BYTES; i++) begin : g_byte
      logic [7:0] len_b, out_b, raw_b;
      assign raw_b = raw_blk[(BYTES-1-i)*8 +: 8];
      if (i >= BYTES - LBYTES) begin : g_len
         localparam int J = i - (BYTES - LBYTES);
         assign len_b = little_len ? bit_len[J*8 +: 8]
                                   : bit_len[(LBYTES-1-J)*8 +: 8];
      end else begin : g_nolen
         assign len_b = 8'h00;
      end
      always_comb begin
         if (RW'(i) < fill_r)                 out_b = raw_b;
         else if (mark_en && RW'(i) == fill_r) out_b = 8'h80;
         else if (len_en)                     out_b = len_b;
         else                                 out_b = 8'h00;
      end
      assign blk_out[(BYTES-1-i)*8 +: 8] = out_b;
   end

endmodule

// File: rtl/hash_ctrl.sv
module hash_ctrl
   import hash_seq_pkg::*;
#(
   parameter int LEN_W  = 28,
   parameter int CNT_W  = 32,
   localparam int BLK_W = BLK_BYTES * 8,
   localparam int IW    = $clog2(BLK_WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_start,
   input  logic [1:0]           cfg_algo,
   input  logic                 cfg_load_iv,
   input  logic                 cfg_close,
   input  logic [LEN_W-1:0]     cfg_len,
   input  logic [CNT_W-1:0]     cfg_cnt_in,
   input  logic                 dma_en,
   input  logic                 wr_valid,
   input  logic [BLK_W-1:0]     pad_blk,
   input  logic                 blk_ready,
   output logic                 buf_we,
   output logic [IW-1:0]        buf_idx,
   output blk_kind_e            pad_kind,
   output logic [FILL_W-1:0]    pad_r,
   output logic                 pad_le,
   output logic [LEN_BYTES*8-1:0] bit_len,
   output logic                 in_ready,
   output logic                 dma_req,
   output logic                 overflow,
   output logic                 blk_valid,
   output logic [BLK_W-1:0]     blk_data,
   output logic                 blk_first,
   output logic [1:0]           blk_algo,
   output logic [CNT_W-1:0]     digest_cnt,
   output logic                 out_ready
);

   typedef enum logic [2:0] {
      ST_IDLE, ST_FILL, ST_PUSH, ST_WAIT, ST_DONE
   } st_e;

   localparam logic [FILL_W-1:0] FULL_B = FILL_W'(BLK_BYTES);
   localparam logic [FILL_W-1:0] LAST_ONE_BLK = FILL_W'(BLK_BYTES - LEN_BYTES - 1);

   st_e                 st_q;
   alg_e                alg_q;
   logic                close_q, first_pend_q, dma_q, ovf_q;
   logic [LEN_W-1:0]    rem_q;
   logic [FILL_W-1:0]   bcnt_q, r_q, work_bytes_q;
   blk_kind_e           kind_q;
   logic [LEN_BYTES*8-1:0] bitlen_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [BLK_W-1:0]    work_q;
   logic                work_vld_q, work_first_q;

   logic [2:0]          nb;
   logic [FILL_W-1:0]   new_b;
   logic                last_w, wr_acc, slot_free, start_ok, push_go, hshake;
   logic [CNT_W-1:0]    start_base;
   logic [LEN_BYTES*8-1:0] start_bits;

   assign in_ready   = (st_q == ST_FILL);
   assign out_ready  = (st_q == ST_DONE);
   assign wr_acc     = wr_valid && in_ready;
   assign nb         = (rem_q > LEN_W'(4)) ? 3'd4 : rem_q[2:0];
   assign new_b      = bcnt_q + FILL_W'(nb);
   assign last_w     = (rem_q <= LEN_W'(4));
   assign hshake     = work_vld_q && blk_ready;
   assign slot_free  = !work_vld_q || blk_ready;
   assign start_ok   = cfg_start && (st_q == ST_IDLE || st_q == ST_DONE);
   assign push_go    = (st_q == ST_PUSH) && slot_free;
   assign start_base = cfg_load_iv ? '0 : cfg_cnt_in;
   assign start_bits = (64'(start_base) + 64'(cfg_len)) << 3;

   assign buf_we     = wr_acc;
   assign buf_idx    = bcnt_q[IW+1:2];
   assign pad_kind   = kind_q;
   assign pad_r      = r_q;
   assign pad_le     = (alg_q == ALG_MD5);
   assign bit_len    = bitlen_q;
   assign dma_req    = dma_q;
   assign overflow   = ovf_q;
   assign blk_valid  = work_vld_q;
   assign blk_data   = work_q;
   assign blk_first  = work_first_q;
   assign blk_algo   = alg_q;
   assign digest_cnt = cnt_q;

   // sequencing of input buffer and padding
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         alg_q        <= ALG_MD5;
         close_q      <= 1'b0;
         first_pend_q <= 1'b0;
         rem_q        <= '0;
         bcnt_q       <= '0;
         r_q          <= '0;
         kind_q       <= BK_RAW;
         bitlen_q     <= '0;
         dma_q        <= 1'b0;
      end else begin
         dma_q <= 1'b0;
         case (st_q)
            ST_IDLE, ST_DONE: begin
               if (start_ok) begin
                  alg_q        <= alg_e'(cfg_algo);
                  close_q      <= cfg_close;
                  first_pend_q <= cfg_load_iv;
                  rem_q        <= cfg_len;
                  bitlen_q     <= start_bits;
                  bcnt_q       <= '0;
                  if (cfg_len != '0) begin
                     st_q  <= ST_FILL;
                     dma_q <= dma_en;
                  end else if (cfg_close) begin
                     kind_q <= BK_FINAL;
                     r_q    <= '0;
                     st_q   <= ST_PUSH;
                  end else begin
                     st_q <= ST_WAIT;
                  end
               end
            end
            ST_FILL: begin
               if (wr_acc) begin
                  rem_q  <= rem_q - LEN_W'(nb);
                  bcnt_q <= new_b;
                  if (new_b == FULL_B) begin
                     kind_q <= BK_RAW;
                     r_q    <= FULL_B;
                     st_q   <= ST_PUSH;
                  end else if (last_w) begin
                     kind_q <= (new_b <= LAST_ONE_BLK) ? BK_FINAL : BK_SPILL;
                     r_q    <= new_b;
                     st_q   <= ST_PUSH;
                  end
               end
            end
            ST_PUSH: begin
               if (slot_free) begin
                  bcnt_q       <= '0;
                  first_pend_q <= 1'b0;
                  case (kind_q)
                     BK_RAW: begin
                        if (rem_q != '0) begin
                           st_q  <= ST_FILL;
                           dma_q <= dma_en;
                        end else if (close_q) begin
                           kind_q <= BK_FINAL;
                           r_q    <= '0;
                        end else begin
                           st_q <= ST_WAIT;
                        end
                     end
                     BK_SPILL: begin
                        kind_q <= BK_LENONLY;
                        r_q    <= '0;
                     end
                     default: st_q <= ST_WAIT;
                  endcase
               end
            end
            ST_WAIT: begin
               if (slot_free) st_q <= ST_DONE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // working storage toward the compression core
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q       <= '0;
         work_vld_q   <= 1'b0;
         work_first_q <= 1'b0;
         work_bytes_q <= '0;
      end else if (push_go) begin
         work_q       <= pad_blk;
         work_vld_q   <= 1'b1;
         work_first_q <= first_pend_q;
         work_bytes_q <= r_q;
      end else if (hshake) begin
         work_vld_q   <= 1'b0;
      end
   end

   // byte count and refused-write flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (start_ok)    cnt_q <= start_base;
         else if (hshake) cnt_q <= cnt_q + CNT_W'(work_bytes_q);
         if (wr_valid && !in_ready) ovf_q <= 1'b1;
         else if (start_ok)         ovf_q <= 1'b0;
      end
   end

endmodule

// File: rtl/hash_seq_top.sv
module hash_seq_top
   import hash_seq_pkg::*;
#(
   parameter int LEN_W = 28,
   parameter int CNT_W = 32,
   localparam int BLK_W = BLK_BYTES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_start,
   input  logic [1:0]       cfg_algo,
   input  logic             cfg_load_iv,
   input  logic             cfg_close,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic [CNT_W-1:0] cfg_cnt_in,
   input  logic             dma_en,
   input  logic             irq_en,
   input  logic             wr_valid,
   input  logic [31:0]      wr_data,
   output logic             in_ready,
   output logic             dma_req,
   output logic             overflow,
   output logic             blk_valid,
   input  logic             blk_ready,
   output logic [511:0]     blk_data,
   output logic             blk_first,
   output logic [1:0]       blk_algo,
   output logic [255:0]     blk_iv,
   output logic [CNT_W-1:0] digest_cnt,
   output logic             out_ready,
   output logic             irq_n
);

   if (LEN_W < 3 || LEN_W > CNT_W || CNT_W > 60) begin : g_bad_width
      $error("hash_seq_top: need 3 <= LEN_W <= CNT_W <= 60");
   end
   if (BLK_W != 512 || WORD_W != 32) begin : g_bad_block
      $error("hash_seq_top: block must be 16 words of 32 bits");
   end

   localparam int IW = $clog2(BLK_WORDS);

   logic                   buf_we, pad_le;
   logic [IW-1:0]          buf_idx;
   logic [BLK_W-1:0]       raw_blk, pad_blk;
   blk_kind_e              pad_kind;
   logic [FILL_W-1:0]      pad_r;
   logic [LEN_BYTES*8-1:0] bit_len;

   hash_inbuf #(.WORDS(BLK_WORDS), .WORD_W(WORD_W)) u_inbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (buf_we),
      .wr_idx  (buf_idx),
      .wr_data (wr_data),
      .raw_blk (raw_blk)
   );

   hash_pad #(.BYTES(BLK_BYTES), .LBYTES(LEN_BYTES)) u_pad (
      .raw_blk    (raw_blk),
      .kind       (pad_kind),
      .fill_r     (pad_r),
      .little_len (pad_le),
      .bit_len    (bit_len),
      .blk_out    (pad_blk)
   );

   hash_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_start   (cfg_start),
      .cfg_algo    (cfg_algo),
      .cfg_load_iv (cfg_load_iv),
      .cfg_close   (cfg_close),
      .cfg_len     (cfg_len),
      .cfg_cnt_in  (cfg_cnt_in),
      .dma_en      (dma_en),
      .wr_valid    (wr_valid),
      .pad_blk     (pad_blk),
      .blk_ready   (blk_ready),
      .buf_we      (buf_we),
      .buf_idx     (buf_idx),
      .pad_kind    (pad_kind),
      .pad_r       (pad_r),
      .pad_le      (pad_le),
      .bit_len     (bit_len),
      .in_ready    (in_ready),
      .dma_req     (dma_req),
      .overflow    (overflow),
      .blk_valid   (blk_valid),
      .blk_data    (blk_data),
      .blk_first   (blk_first),
      .blk_algo    (blk_algo),
      .digest_cnt  (digest_cnt),
      .out_ready   (out_ready)
   );

   assign blk_iv = iv_words(alg_e'(blk_algo));
   assign irq_n  = !(out_ready && irq_en);

endmodule

// File: rtl/hash_seq_chk.sv
module hash_seq_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_start,
   input logic             wr_valid,
   input logic             in_ready,
   input logic             dma_req,
   input logic             overflow,
   input logic             blk_valid,
   input logic             blk_ready,
   input logic [511:0]     blk_data,
   input logic [CNT_W-1:0] digest_cnt,
   input logic             out_ready,
   input logic             irq_n
);

   AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_ready)); // R3

   AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid && !blk_ready |=> blk_valid && $stable(blk_data)); // R9

   AST_DMA_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> in_ready); // R10

   AST_IRQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> out_ready); // R11

   AST_CNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_start |=> digest_cnt >= $past(digest_cnt)); // R12

   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !in_ready |=> overflow); // R13

   AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      overflow && !cfg_start |=> overflow); // R13

endmodule

bind hash_seq_top hash_seq_chk #(.CNT_W(CNT_W)) u_hash_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_start  (cfg_start),
   .wr_valid   (wr_valid),
   .in_ready   (in_ready),
   .dma_req    (dma_req),
   .overflow   (overflow),
   .blk_valid  (blk_valid),
   .blk_ready  (blk_ready),
   .blk_data   (blk_data),
   .digest_cnt (digest_cnt),
   .out_ready  (out_ready),
   .irq_n      (irq_n)
);

// File: tb/test_hash_seq_top.sv
module test_hash_seq_top;

   localparam int LEN_W = 28;
   localparam int CNT_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_start = 1'b0;
   logic [1:0]       cfg_algo = '0;
   logic             cfg_load_iv = 1'b0;
   logic             cfg_close = 1'b0;
   logic [LEN_W-1:0] cfg_len = '0;
   logic [CNT_W-1:0] cfg_cnt_in = '0;
   logic             dma_en = 1'b0;
   logic             irq_en = 1'b0;
   logic             wr_valid = 1'b0;
   logic [31:0]      wr_data = '0;
   logic             blk_ready = 1'b0;
   logic             in_ready, dma_req, overflow, blk_valid, blk_first;
   logic             out_ready, irq_n;
   logic [511:0]     blk_data;
   logic [1:0]       blk_algo;
   logic [255:0]     blk_iv;
   logic [CNT_W-1:0] digest_cnt;

   always #10 clk = ~clk;

   hash_seq_top #(.LEN_W(LEN_W), .CNT_W(CNT_W)) i_hash_seq_top (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_algo(cfg_algo),
      .cfg_load_iv(cfg_load_iv), .cfg_close(cfg_close), .cfg_len(cfg_len),
      .cfg_cnt_in(cfg_cnt_in), .dma_en(dma_en), .irq_en(irq_en),
      .wr_valid(wr_valid), .wr_data(wr_data), .in_ready(in_ready),
      .dma_req(dma_req), .overflow(overflow), .blk_valid(blk_valid),
      .blk_ready(blk_ready), .blk_data(blk_data), .blk_first(blk_first),
      .blk_algo(blk_algo), .blk_iv(blk_iv), .digest_cnt(digest_cnt),
      .out_ready(out_ready), .irq_n(irq_n)
   );

   int          checks = 0;
   int          errors = 0;
   int          cyc = 0;
   logic [7:0]  msg [0:255];
   int          cur_len = 0;
   int          wr_total = 0;
   int          wr_next = 0;
   bit          wr_on = 1'b0;
   bit          junk_wr = 1'b0;
   int          rdy_mode = 0;
   int          dma_seen = 0;
   logic [7:0]  exp_q [$];
   bit          exp_first = 1'b0;
   logic [1:0]  exp_alg = '0;
   string       tag = "R4";

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [255:0] iv_ref(input logic [1:0] a);
      case (a)
         2'd0: return {32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476, 128'h0};
         2'd1: return {32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476,
                       32'hc3d2e1f0, 96'h0};
         2'd2: return {32'hc1059ed8, 32'h367cd507, 32'h3070dd17, 32'hf70e5939,
                       32'hffc00b31, 32'h68581511, 32'h64f98fa7, 32'hbefa4fa4};
         default: return {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                          32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
      endcase
   endfunction

   function automatic logic [31:0] word_of(input int w);
      logic [31:0] d;
      for (int b = 0; b < 4; b++) begin
         d[31-8*b -: 8] = (4*w + b < cur_len) ? msg[4*w + b] : 8'ha5;
      end
      return d;
   endfunction

   // message word source: processor-style or DMA-style, paced by in_ready
   always @(negedge clk) begin
      if (junk_wr) begin
         wr_valid = 1'b1;
         wr_data  = 32'hdeadbeef;
      end else if (wr_on && in_ready && wr_next < wr_total) begin
         wr_valid = 1'b1;
         wr_data  = word_of(wr_next);
         wr_next++;
      end else begin
         wr_valid = 1'b0;
      end
   end

   // core side: ready pattern and comparison of every accepted block
   always @(negedge clk) begin
      logic [511:0] e;
      cyc++;
      blk_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (dma_req) dma_seen++;
      if (rst_n && blk_valid && blk_ready) begin
         if (exp_q.size() < 64) begin
            chk(1'b0, tag, "unexpected block", blk_data, '0);
         end else begin
            for (int i = 0; i < 64; i++) e[511-8*i -: 8] = exp_q.pop_front();
            chk(blk_data == e, tag, "block bytes", blk_data, e);
            chk(blk_first == exp_first, "R2", "first flag", 512'(blk_first), 512'(exp_first));
            if (exp_first) begin
               chk(blk_iv == iv_ref(exp_alg), "R1", "initial words", 512'(blk_iv),
                   512'(iv_ref(exp_alg)));
               chk(blk_algo == exp_alg, "R1", "algorithm", 512'(blk_algo), 512'(exp_alg));
            end
            exp_first = 1'b0;
         end
      end
   end

   task automatic run_hash(input logic [1:0] alg, input bit load, input bit close,
                           input int len, input int base, input int seed,
                           input int rmode, input bit dma, input bit irq,
                           input string t);
      longint bits;
      int     exp_dma;
      for (int k = 0; k < 256; k++) msg[k] = 8'((k * 13 + seed) & 255);
      exp_q.delete();
      for (int k = 0; k < len; k++) exp_q.push_back(msg[k]);
      if (close) begin
         bits = 64'(load ? 0 : base) + 64'(len);
         bits = bits * 8;
         exp_q.push_back(8'h80);
         while (exp_q.size() % 64 != 56) exp_q.push_back(8'h00);
         for (int j = 0; j < 8; j++) begin
            if (alg == 2'd0) exp_q.push_back(8'(bits >> (8*j)));
            else             exp_q.push_back(8'(bits >> (8*(7-j))));
         end
      end
      exp_first = load;
      exp_alg   = alg;
      tag       = t;
      rdy_mode  = rmode;
      cur_len   = len;
      wr_total  = (len + 3) / 4;
      wr_next   = 0;
      dma_seen  = 0;
      exp_dma   = dma ? (len + 63) / 64 : 0;
      @(negedge clk);
      cfg_algo = alg; cfg_load_iv = load; cfg_close = close;
      cfg_len = LEN_W'(len); cfg_cnt_in = CNT_W'(base);
      dma_en = dma; irq_en = irq; wr_on = 1'b1;
      cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
      if (len > 0) begin
         chk(in_ready == 1'b1, "R3", "in_ready after start", 512'(in_ready), 512'(1));
         chk(dma_req == dma, "R10", "request after start", 512'(dma_req), 512'(dma));
      end
      chk(overflow == 1'b0, "R13", "overflow cleared by start", 512'(overflow), 512'(0));
      begin
         int n = 0;
         while (!out_ready && n < 3000) begin
            @(negedge clk);
            n++;
         end
      end
      chk(out_ready == 1'b1, "R11", "job completion", 512'(out_ready), 512'(1));
      chk(exp_q.size() == 0, t, "bytes left unsent", 512'(exp_q.size()), 512'(0));
      chk(digest_cnt == CNT_W'((load ? 0 : base) + len), "R12", "byte count",
          512'(digest_cnt), 512'((load ? 0 : base) + len));
      chk(irq_n == !irq, "R11", "interrupt level", 512'(irq_n), 512'(!irq));
      chk(dma_seen == exp_dma, "R10", "request count", 512'(dma_seen), 512'(exp_dma));
      chk(in_ready == 1'b0, "R3", "in_ready when done", 512'(in_ready), 512'(0));
      wr_on = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 0 && out_ready == 0 && blk_valid == 0 && irq_n == 1 &&
          overflow == 0 && dma_req == 0, "R3", "reset outputs",
          512'({in_ready, out_ready, blk_valid, irq_n, overflow, dma_req}), 512'(6'b000100));

      run_hash(2'd3, 1, 1, 3,   0,   1, 0, 1, 1, "R8");  // short tail in one word
      run_hash(2'd1, 1, 1, 55,  0,   2, 0, 0, 1, "R5");  // fills to the last fitting byte
      run_hash(2'd2, 1, 1, 56,  0,   3, 1, 1, 0, "R5");  // spills into an extra block
      run_hash(2'd0, 1, 1, 64,  0,   4, 0, 0, 1, "R6");  // boundary, little-endian length
      run_hash(2'd3, 1, 1, 130, 0,   5, 1, 1, 1, "R9");  // several blocks under back-pressure
      run_hash(2'd3, 1, 0, 128, 0,   6, 0, 1, 0, "R7");  // intermediate, no padding
      run_hash(2'd3, 0, 1, 10,  128, 7, 0, 0, 1, "R2");  // resume from saved count
      run_hash(2'd1, 1, 1, 0,   0,   8, 0, 1, 1, "R5");  // empty message
      run_hash(2'd0, 1, 1, 61,  0,   9, 1, 0, 1, "R8");  // one byte in the final word

      // refused write while done (R13)
      begin
         logic [CNT_W-1:0] cnt_before;
         cnt_before = digest_cnt;
         @(negedge clk);
         junk_wr = 1'b1;
         @(negedge clk);
         junk_wr = 1'b0;
         chk(overflow == 1'b1, "R13", "overflow set", 512'(overflow), 512'(1));
         chk(digest_cnt == cnt_before, "R13", "count untouched", 512'(digest_cnt),
             512'(cnt_before));
         chk(out_ready == 1'b1 && blk_valid == 1'b0, "R13", "state untouched",
             512'({out_ready, blk_valid}), 512'(2'b10));
      end
      run_hash(2'd2, 1, 1, 20, 0, 10, 0, 0, 0, "R4");   // clean block after refused write

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R11 watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule